// File: doc/BRIEF.md
# LFSR Rate Divider

This block produces a single-cycle tick once every N enabled clocks. It is meant for low-cost rate generation, such as a serial baud tick taken from a fast system clock. Its counter is a maximal-length shift register with XNOR feedback rather than a binary incrementer. Each stage therefore needs no carry chain, and the only wide logic is one equality compare.

N is fixed when the block is built. Three things are worked out at that point from N alone: the register width, the feedback taps for that width, and the state the register reaches after N−1 shifts from all-zeros. That state is the terminal pattern. When the register shows it, the tick output goes high. On the next enabled clock the register returns to all-zeros, so the sequence starts again.

A clock enable gates every update. A synchronous clear, also gated by the enable, restarts the count. An active-low asynchronous reset puts the register in its all-zeros start state.

Top module: `lfsr_div_top`

## Requirements
- R1: With `en_i` held high and `clear_i` low, `tick_o` is high for exactly one clock in every N clocks.
- R2: After `rst_ni` is released, `tick_o` is low. It first rises after exactly N−1 enabled clock edges.
- R3: While `en_i` is low, the register holds its state. Those clocks do not count toward the period.
- R4: `clear_i` sampled high on an enabled edge sends the register to its start state, so the next tick follows N−1 enabled edges later. `clear_i` has no effect on an edge where `en_i` is low.
- R5: The width is the smallest B with N < 2^B, for any N from 2 to 2^30. The period stays exact whether a width uses two or four feedback taps.
- R6: `tick_o` depends only on the register state. If the enable drops while the terminal state is held, the tick stays high for every stalled clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Clock enable for all stages |
| clear_i | input | 1 | Synchronous restart, qualified by `en_i` |
| tick_o | output | 1 | Terminal-state pulse |

## Verification
The assertions assume that `en_i` and `clear_i` are clean, synchronous levels. They also assume that reset is the only way the register leaves its cycle.

The period assertion counts enabled edges from the last restart. It therefore depends on `clear_i` being honoured only on enabled edges.

The stimulus drives the inputs only on falling edges. It holds the enable high for runs longer than the largest period, and it inserts stalls, including one in the terminal state. It issues clears both with and without the enable, so that every input combination the assertions depend on actually occurs.

// File: rtl/lfsr_div_pkg.sv
package lfsr_div_pkg;

  localparam int unsigned MaxW = 31;

  typedef logic [MaxW-1:0]            vec_t;
  typedef logic [MaxW-1:0][MaxW-1:0]  mat_t;   // mat[j]: image of basis bit j
  typedef struct packed {
    mat_t lin;
    vec_t ofs;
  } aff_t;                                     // s -> lin*s ^ ofs over GF(2)

  // smallest b with n < 2^b
  function automatic int unsigned width_for(input longint unsigned n);
    int unsigned b;
    b = 0;
    for (int i = 1; i <= 32; i++)
      if (b == 0 && n < (64'd1 << i)) b = i;
    return b;
  endfunction

  // four 1-based stage numbers, 0 = unused slot
  function automatic logic [19:0] taps_for(input int unsigned b);
    case (b)
      2:  return {5'd0, 5'd0, 5'd1, 5'd2};
      3:  return {5'd0, 5'd0, 5'd2, 5'd3};
      4:  return {5'd0, 5'd0, 5'd3, 5'd4};
      5:  return {5'd0, 5'd0, 5'd3, 5'd5};
      6:  return {5'd0, 5'd0, 5'd5, 5'd6};
      7:  return {5'd0, 5'd0, 5'd6, 5'd7};
      8:  return {5'd4, 5'd5, 5'd6, 5'd8};
      9:  return {5'd0, 5'd0, 5'd5, 5'd9};
      10: return {5'd0, 5'd0, 5'd7, 5'd10};
      11: return {5'd0, 5'd0, 5'd9, 5'd11};
      12: return {5'd1, 5'd4, 5'd6, 5'd12};
      13: return {5'd1, 5'd3, 5'd4, 5'd13};
      14: return {5'd1, 5'd3, 5'd5, 5'd14};
      15: return {5'd0, 5'd0, 5'd14, 5'd15};
      16: return {5'd4, 5'd13, 5'd15, 5'd16};
      17: return {5'd0, 5'd0, 5'd14, 5'd17};
      18: return {5'd0, 5'd0, 5'd11, 5'd18};
      19: return {5'd1, 5'd2, 5'd6, 5'd19};
      20: return {5'd0, 5'd0, 5'd17, 5'd20};
      21: return {5'd0, 5'd0, 5'd19, 5'd21};
      22: return {5'd0, 5'd0, 5'd21, 5'd22};
      23: return {5'd0, 5'd0, 5'd18, 5'd23};
      24: return {5'd17, 5'd22, 5'd23, 5'd24};
      25: return {5'd0, 5'd0, 5'd22, 5'd25};
      26: return {5'd1, 5'd2, 5'd6, 5'd26};
      27: return {5'd1, 5'd2, 5'd5, 5'd27};
      28: return {5'd0, 5'd0, 5'd25, 5'd28};
      29: return {5'd0, 5'd0, 5'd27, 5'd29};
      30: return {5'd1, 5'd4, 5'd6, 5'd30};
      31: return {5'd0, 5'd0, 5'd28, 5'd31};
      default: return '0;
    endcase
  endfunction

  function automatic vec_t lin_apply(input mat_t m, input vec_t v);
    vec_t r;
    r = '0;
    for (int j = 0; j < int'(MaxW); j++)
      if (v[j]) r = r ^ m[j];
    return r;
  endfunction

  // a after b
  function automatic aff_t aff_compose(input aff_t a, input aff_t b);
    aff_t r;
    for (int j = 0; j < int'(MaxW); j++)
      r.lin[j] = lin_apply(a.lin, b.lin[j]);
    r.ofs = lin_apply(a.lin, b.ofs) ^ a.ofs;
    return r;
  endfunction

  // one enabled shift of a b-wide XNOR register
  function automatic aff_t step_map(input int unsigned b);
    aff_t        r;
    logic [19:0] t;
    t     = taps_for(b);
    r.lin = '0;
    r.ofs = '0;
    r.ofs[0] = 1'b1;                           // XNOR = inverted XOR
    for (int j = 0; j < int'(MaxW); j++) begin
      if (j + 1 < int'(b)) r.lin[j][j+1] = 1'b1;
      for (int k = 0; k < 4; k++)
        if (int'(t[k*5 +: 5]) == j + 1) r.lin[j][0] = ~r.lin[j][0];
    end
    return r;
  endfunction

  // state after n-1 shifts from zero, by square-and-multiply
  function automatic vec_t terminal_for(input longint unsigned n, input int unsigned b);
    aff_t            acc;
    aff_t            pw;
    longint unsigned e;
    acc = '0;
    for (int j = 0; j < int'(MaxW); j++) acc.lin[j][j] = 1'b1;
    pw = step_map(b);
    e  = n - 1;
    for (int k = 0; k < 32; k++) begin
      if (e[k]) acc = aff_compose(pw, acc);
      pw = aff_compose(pw, pw);
    end
    return acc.ofs;
  endfunction

endpackage

// File: rtl/lfsr_div_shift.sv
module lfsr_div_shift #(
  parameter int unsigned W    = 12,
  parameter logic [19:0] TAPS = 20'd0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         clr_i,
  output logic [W-1:0] state_o
);

  localparam int unsigned NumTaps = 4;

  logic [W-1:0]         state_q;
  logic [NumTaps-1:0]   tap_bit;
  logic                 fb;

  for (genvar k = 0; k < NumTaps; k++) begin : g_tap
    localparam int unsigned Pos = int'(TAPS[k*5 +: 5]);
    if (Pos == 0 || Pos > W) begin : g_unused
      assign tap_bit[k] = 1'b0;
    end else begin : g_used
      assign tap_bit[k] = state_q[Pos-1];
    end
  end

  assign fb = ~^tap_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= '0;
    else if (en_i)  state_q <= clr_i ? '0 : {state_q[W-2:0], fb};
  end

  assign state_o = state_q;

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(state_q));

  p_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && clr_i |=> state_q == '0);

  p_no_lockup_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '1);

endmodule

// File: rtl/lfsr_div_match.sv
module lfsr_div_match #(
  parameter int unsigned  W    = 12,
  parameter logic [W-1:0] TERM = '1
) (
  input  logic [W-1:0] state_i,
  output logic         hit_o
);

  assign hit_o = (state_i == TERM);

  always_comb begin
    a_term_nonzero_r5: assert (TERM != '0);
  end

endmodule

// File: rtl/lfsr_div_top.sv
module lfsr_div_top #(
  parameter int unsigned N = 2604
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clear_i,
  output logic tick_o
);
  import lfsr_div_pkg::*;

  localparam int unsigned  W        = width_for(longint'(N));
  localparam logic [19:0]  Taps     = taps_for(W);
  localparam vec_t         TermFull = terminal_for(longint'(N), W);
  localparam logic [W-1:0] Term     = TermFull[W-1:0];

  if (N < 2 || N > (32'd1 << 30)) begin : g_bad_n
    $error("lfsr_div_top: N out of range");
  end

  logic [W-1:0] state;
  logic         hit;
  logic         restart;

  assign restart = hit | clear_i;

  lfsr_div_shift #(.W(W), .TAPS(Taps)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .clr_i   (restart),
    .state_o (state)
  );

  lfsr_div_match #(.W(W), .TERM(Term)) u_match (
    .state_i (state),
    .hit_o   (hit)
  );

  assign tick_o = hit;

  // enabled edges since last restart, for the period check
  logic [31:0] gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   gap_q <= '0;
    else if (en_i) gap_q <= (tick_o || clear_i) ? 32'd0 : gap_q + 32'd1;
  end

  p_period_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> gap_q == N - 1);

  p_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && tick_o |=> !tick_o);

  p_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && tick_o |=> tick_o);

endmodule

// File: tb/lfsr_div_top_test.sv
module lfsr_div_top_test;

  localparam int ClkPeriod = 10;
  localparam int NumDut    = 4;
  localparam int Watchdog  = 190000;
  localparam int DivTab [NumDut] = '{5, 100, 2604, 40000};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_i = 1'b0;
  logic clear_i = 1'b0;
  logic [NumDut-1:0] tick_v;

  always #(ClkPeriod/2) clk = ~clk;

  lfsr_div_top #(.N(DivTab[0])) uut_s (.clk_i(clk), .rst_ni(rst_n), .en_i(en_i), .clear_i(clear_i), .tick_o(tick_v[0]));
  lfsr_div_top #(.N(DivTab[1])) uut_m (.clk_i(clk), .rst_ni(rst_n), .en_i(en_i), .clear_i(clear_i), .tick_o(tick_v[1]));
  lfsr_div_top #(.N(DivTab[2])) uut   (.clk_i(clk), .rst_ni(rst_n), .en_i(en_i), .clear_i(clear_i), .tick_o(tick_v[2]));
  lfsr_div_top #(.N(DivTab[3])) uut_l (.clk_i(clk), .rst_ni(rst_n), .en_i(en_i), .clear_i(clear_i), .tick_o(tick_v[3]));

  int compared = 0;
  int mismatched = 0;
  int cnt [NumDut];
  int ticks_seen [NumDut];
  bit done = 1'b0;

  logic [NumDut-1:0] exp_q [$];
  string             tag_q [$];

  task automatic check_bit(input string tag, input int k, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: N=%0d tick=%0b expected %0b", tag, DivTab[k], act, exp);
    end
  endtask

  // driver: applies one cycle of inputs and queues the expected ticks
  task automatic drive(input bit en, input bit clr, input string tag);
    logic [NumDut-1:0] e;
    @(negedge clk);
    en_i    = en;
    clear_i = clr;
    @(posedge clk);
    for (int k = 0; k < NumDut; k++) begin
      if (en) cnt[k] = (clr || cnt[k] == DivTab[k] - 1) ? 0 : cnt[k] + 1;
      e[k] = (cnt[k] == DivTab[k] - 1);
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      logic [NumDut-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      for (int k = 0; k < NumDut; k++) begin
        check_bit(t, k, tick_v[k], e[k]);
        if (tick_v[k] === 1'b1) ticks_seen[k]++;
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (Watchdog) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    for (int k = 0; k < NumDut; k++) begin
      cnt[k] = 0;
      ticks_seen[k] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    // R2: reset state
    for (int k = 0; k < NumDut; k++) check_bit("R2 reset", k, tick_v[k], 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: first tick after N-1 edges
    for (int i = 0; i < 10; i++) drive(1'b1, 1'b0, "R2");
    // R1/R5: free run past two periods of the largest divisor
    for (int i = 0; i < 81000; i++) drive(1'b1, 1'b0, "R1");

    // R3: stall mid-count
    for (int i = 0; i < 17; i++) drive(1'b0, 1'b0, "R3");
    for (int i = 0; i < 300; i++) drive(1'b1, 1'b0, "R3");

    // R6: stall while the small divider shows its terminal state
    while (cnt[0] != DivTab[0] - 1) drive(1'b1, 1'b0, "R6");
    for (int i = 0; i < 6; i++) drive(1'b0, 1'b0, "R6");
    for (int i = 0; i < 20; i++) drive(1'b1, 1'b0, "R6");

    // R4: clear without enable is ignored
    for (int i = 0; i < 3; i++) drive(1'b0, 1'b1, "R4");
    for (int i = 0; i < 1500; i++) drive(1'b1, 1'b0, "R4");
    // R4: clear with enable restarts the full period
    drive(1'b1, 1'b1, "R4");
    for (int i = 0; i < 42000; i++) drive(1'b1, 1'b0, "R4");

    repeat (2) @(negedge clk);
    // R5: every width produced ticks, the largest at least three times
    for (int k = 0; k < NumDut; k++) begin
      compared++;
      if (ticks_seen[k] < 3) begin
        mismatched++;
        $display("FAIL R5: N=%0d ticks=%0d expected >= 3", DivTab[k], ticks_seen[k]);
      end
    end
    finish_run();
  end

endmodule